// File: doc/BRIEF.md
# Programmable priority interrupt selector

This block watches eight active-low external interrupt lines and chooses one of them to offer to a processor. Each line has its own 4-bit priority. A priority of zero shuts the line off, and among the other lines the highest value wins. Each line is sampled through a two-flop synchroniser. Software sets each line to edge detection (a falling edge) or level detection (a low level). A detected request is latched as pending. It stays pending until the CPU acknowledges that exact line, until software masks the line, or until the block is switched out of individual-line mode. A level request therefore survives its source going away.

The winning pending line is offered only when its priority is strictly above the CPU's current 4-bit mask level. The block drives the winning line index and priority level on its outputs. Software uses a small register port with two address bits. The registers are:

| Address | Contents |
|---|---|
| 0 | Priority word |
| 1 | Control word: bit 8 enables individual-line mode; bits 7:0 select level detection per line |
| 2 | Per-line mask bits |
| 3 | Reads zero |

Top module: `prio_irq_select`

## Requirements
- R1: After reset, the priority word, the control word and the mask word all read 0, and `int_req_o`, `int_line_o` and `int_level_o` are 0.
- R2: The priority word at address 0 is 32 bits wide. Line n uses bits [31-4n : 28-4n], so line 0 is in bits 31:28 and line 7 is in bits 3:0. A read returns the last written word unchanged.
- R3: A line whose priority field is 0 is never offered, even when it has a pending request.
- R4: Among pending lines, the one with the numerically largest priority wins. When priorities are equal, the lower-numbered line wins.
- R5: `int_req_o` is 1 only when the winning priority is strictly greater than `cpu_level_i`. When it is 1, `int_line_o` and `int_level_o` carry the winner. When it is 0, both are 0.
- R6: When control bit 8 is 0, no line is offered, no request latches, and any pending requests are dropped at the edge that clears the bit.
- R7: An edge-mode line (control bit n = 0) latches a request on a falling edge. A low driven just after one rising edge appears on the outputs after the third rising edge that follows.
- R8: A level-mode line (control bit n = 1) latches a request while its synchronised input is low. The request stays pending after the input returns high, until it is acknowledged.
- R9: An acknowledge with `ack_valid_i` = 1 clears only the pending request of line `ack_line_i`, at that same clock edge. The clear takes precedence over a new request arriving at the same edge.
- R10: Writing 1 to mask bit n at address 2 discards line n's pending request at the write edge. While the bit is set, no request latches on line n.
- R11: A write to the priority word changes arbitration from the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 8 | External interrupt lines, active low |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| cpu_level_i | input | 4 | CPU's current interrupt mask level |
| ack_valid_i | input | 1 | CPU accepts an interrupt |
| ack_line_i | input | 3 | Index of the accepted line |
| int_req_o | output | 1 | An interrupt is offered |
| int_line_o | output | 3 | Index of the offered line |
| int_level_o | output | 4 | Priority of the offered line |

## Verification
Several situations can only be observed through arbitration, because the pending latches are not visible on any port:

- **Level hold.** A level request is still held after its source has been released for several cycles. The bench holds a level-mode line low long enough to latch, releases it, waits, and only then acknowledges.
- **Hidden pending on a zero-priority line.** The bench latches a request on a line whose priority is 0, confirms nothing is offered, and then rewrites the priority word. The hidden request appears in the cycle after the write.
- **Targeted clears.** Mask-discard and mode-off-discard are shown the same way: the line is unmasked (or the mode re-enabled) and the bench confirms the old request does not come back.

A behavioural model, driven by the same stimulus, is compared with the outputs on every cycle.

// File: rtl/prio_irq_select.sv
module prio_irq_select #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int WORD_W   = NUM_LINES * PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LINES-1:0] irq_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [PRIO_W-1:0] cpu_level_i,
  input  logic              ack_valid_i,
  input  logic [IDX_W-1:0]  ack_line_i,
  output logic              int_req_o,
  output logic [IDX_W-1:0]  int_line_o,
  output logic [PRIO_W-1:0] int_level_o
);

  localparam logic [1:0] A_PRIO = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;

  logic [WORD_W-1:0]    prio_q;
  logic                 mode_q, mode_d;
  logic [NUM_LINES-1:0] lvl_q, lvl_d, mask_q, mask_d;
  logic [NUM_LINES-1:0] sync1_q, sync2_q, sync3_q;
  logic [NUM_LINES-1:0] pend_q, pend_d, hit, fall, set_v, clr_v;
  logic [PRIO_W-1:0]    fld [NUM_LINES];
  logic [PRIO_W-1:0]    best_lvl;
  logic [IDX_W-1:0]     best_idx;

  wire wr_prio = reg_we_i && (reg_addr_i == A_PRIO);
  wire wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  wire wr_mask = reg_we_i && (reg_addr_i == A_MASK);

  assign mode_d = wr_ctrl ? reg_wdata_i[NUM_LINES] : mode_q;
  assign lvl_d  = wr_ctrl ? reg_wdata_i[NUM_LINES-1:0] : lvl_q;
  assign mask_d = wr_mask ? reg_wdata_i[NUM_LINES-1:0] : mask_q;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    assign fld[n] = prio_q[WORD_W-1-n*PRIO_W -: PRIO_W];
    assign hit[n] = ack_valid_i && (ack_line_i == IDX_W'(n));
  end

  assign fall   = sync3_q & ~sync2_q;
  assign set_v  = {NUM_LINES{mode_d}} & ~mask_d & ((lvl_q & ~sync2_q) | (~lvl_q & fall));
  assign clr_v  = hit | mask_d | {NUM_LINES{~mode_d}};
  assign pend_d = (pend_q | set_v) & ~clr_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      mode_q  <= 1'b0;
      lvl_q   <= '0;
      mask_q  <= '0;
      sync1_q <= '1;
      sync2_q <= '1;
      sync3_q <= '1;
      pend_q  <= '0;
    end else begin
      if (wr_prio) prio_q <= reg_wdata_i;
      mode_q  <= mode_d;
      lvl_q   <= lvl_d;
      mask_q  <= mask_d;
      sync1_q <= irq_ni;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (pend_q[n] && (fld[n] > best_lvl)) begin
        best_lvl = fld[n];
        best_idx = IDX_W'(n);
      end
    end
  end

  assign int_req_o   = mode_q && (best_lvl > cpu_level_i);
  assign int_line_o  = int_req_o ? best_idx : '0;
  assign int_level_o = int_req_o ? best_lvl : '0;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_PRIO: reg_rdata_o = prio_q;
      A_CTRL: begin
        reg_rdata_o[NUM_LINES-1:0] = lvl_q;
        reg_rdata_o[NUM_LINES]     = mode_q;
      end
      A_MASK: reg_rdata_o[NUM_LINES-1:0] = mask_q;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_prio |=> $stable(prio_q)); // R2
  AST_WINNER_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> (int_level_o != '0) && (int_level_o == fld[int_line_o])); // R3
  AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> pend_q[int_line_o]); // R4
  AST_ABOVE_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> (int_level_o > cpu_level_i)); // R5
  AST_MODE_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (pend_q == '0)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_i |=> !pend_q[$past(ack_line_i)]); // R9
  AST_MASK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & mask_q) == '0); // R10

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_hold
    AST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[n] && !hit[n] && mode_d && !mask_d[n]) |=> pend_q[n]); // R8
  end

endmodule

// File: tb/prio_irq_select_tb.sv
module prio_irq_select_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n = 8'hFF;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cpu_level = 4'd0;
  logic        ack_v = 1'b0;
  logic [2:0]  ack_line = 3'd0;
  logic        int_req;
  logic [2:0]  int_line;
  logic [3:0]  int_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_select dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cpu_level_i(cpu_level), .ack_valid_i(ack_v), .ack_line_i(ack_line),
    .int_req_o(int_req), .int_line_o(int_line), .int_level_o(int_level)
  );

  // behavioural reference
  int       m_prio [8];
  bit [7:0] m_lvl, m_mask, m_pend, m_s1, m_s2, m_s3, nmask;
  bit       m_mode, nmode, fall_b, set_b;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_prio[i]) m_prio[i] = 0;
      m_lvl = '0; m_mask = '0; m_pend = '0; m_mode = 0;
      m_s1 = '1; m_s2 = '1; m_s3 = '1;
    end else begin
      nmode = m_mode;
      nmask = m_mask;
      if (we && addr == 2'd1) nmode = wdata[8];
      if (we && addr == 2'd2) nmask = wdata[7:0];
      for (int i = 0; i < 8; i++) begin
        fall_b = m_s3[i] && !m_s2[i];
        set_b  = nmode && !nmask[i] && (m_lvl[i] ? !m_s2[i] : fall_b);
        if (!nmode || nmask[i] || (ack_v && ack_line == 3'(i))) m_pend[i] = 0;
        else if (set_b) m_pend[i] = 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_n;
      if (we && addr == 2'd0)
        for (int i = 0; i < 8; i++) m_prio[i] = int'(wdata[31-4*i -: 4]);
      if (we && addr == 2'd1) m_lvl = wdata[7:0];
      m_mode = nmode;
      m_mask = nmask;
    end
  end

  task automatic model_out(output bit r, output int idx, output int lv);
    r = 0; idx = 0; lv = 0;
    for (int p = 15; p >= 1 && !r; p--)
      for (int i = 0; i < 8 && !r; i++)
        if (m_pend[i] && m_prio[i] == p && p > int'(cpu_level)) begin
          r = 1; idx = i; lv = p;
        end
  endtask

  function automatic logic [31:0] model_rd();
    logic [31:0] v = '0;
    case (addr)
      2'd0: for (int i = 0; i < 8; i++) v[31-4*i -: 4] = 4'(m_prio[i]);
      2'd1: v = {23'd0, m_mode, m_lvl};
      2'd2: v = {24'd0, m_mask};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (live && !done) begin
      bit r; int idx; int lv;
      model_out(r, idx, lv);
      checks++;
      if (int_req !== r || (r && (int'(int_line) != idx || int'(int_level) != lv)) ||
          (!r && (int_line !== 3'd0 || int_level !== 4'd0)) || rdata !== model_rd()) begin
        errors++;
        $display("FAIL cycle model (R4 R5 R7 R8) actual=%0d/%0d/%0d/%h expected=%0d/%0d/%0d/%h",
                 int_req, int_line, int_level, rdata, r, idx, lv, model_rd());
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ack(int line);
    ack_v = 1'b1; ack_line = 3'(line);
    step();
    ack_v = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m, int low_cycles);
    irq_n = irq_n & ~m;
    step(low_cycles);
    irq_n = irq_n | m;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] PW = 32'h5609_2861; // l0=5 l1=6 l2=0 l3=9 l4=2 l5=8 l6=6 l7=1

  initial begin
    logic [31:0] d;
    step(3);
    // R1 reset state
    chk("R1 req", int'(int_req), 0);
    rd(2'd0, d); chk("R1 prio word", int'(d), 0);
    rd(2'd1, d); chk("R1 ctrl word", int'(d), 0);
    rd(2'd2, d); chk("R1 mask word", int'(d), 0);
    rst_n = 1'b1;
    step();
    live = 1;

    // R2 read back
    wr(2'd0, 32'hA1B2_C3D4);
    rd(2'd0, d); chk("R2 readback a", int'(d), int'(32'hA1B2_C3D4));
    wr(2'd0, PW);
    rd(2'd0, d); chk("R2 readback b", int'(d), int'(PW));
    wr(2'd1, 32'h100);

    // R7 edge latency on line 3
    irq_n[3] = 1'b0;
    step(2); chk("R7 not yet", int'(int_req), 0);
    step();  chk("R7 req", int'(int_req), 1);
    chk("R7 line", int'(int_line), 3);
    chk("R7 level", int'(int_level), 9);
    irq_n[3] = 1'b1;

    // R4/R9 targeted ack
    pulse(8'h01, 3);
    chk("R4 higher wins", int'(int_line), 3);
    ack(0);
    chk("R9 other line kept", int'(int_line), 3);
    ack(3);
    chk("R9 cleared", int'(int_req), 0);

    // R4 tie: lines 1 and 6 both priority 6
    pulse(8'h42, 3);
    chk("R4 tie lower index", int'(int_line), 1);
    ack(1);
    chk("R4 tie next", int'(int_line), 6);
    ack(6);
    chk("R4 empty", int'(int_req), 0);

    // R5 cpu level compare on line 5 (priority 8)
    cpu_level = 4'd8;
    pulse(8'h20, 3);
    chk("R5 equal blocked", int'(int_req), 0);
    chk("R5 idx zero", int'(int_line), 0);
    cpu_level = 4'd7; #1;
    chk("R5 above", int'(int_req), 1);
    chk("R5 level", int'(int_level), 8);
    cpu_level = 4'd0;
    ack(5);

    // R3 zero priority line 2, R11 write takes effect
    pulse(8'h04, 3);
    step(2);
    chk("R3 zero field silent", int'(int_req), 0);
    wr(2'd0, PW | 32'h00F0_0000);
    chk("R11 new priority", int'(int_line), 2);
    chk("R11 new level", int'(int_level), 15);
    ack(2);
    wr(2'd0, PW);

    // R8 level hold on line 4
    wr(2'd1, 32'h110);
    irq_n[4] = 1'b0;
    step(3);
    chk("R8 latched", int'(int_line), 4);
    irq_n[4] = 1'b1;
    step(5);
    chk("R8 held", int'(int_req), 1);
    ack(4);
    chk("R8 released by ack", int'(int_req), 0);

    // R10 mask discards and blocks
    pulse(8'h10, 3);
    step(3);
    chk("R10 pending", int'(int_req), 1);
    wr(2'd2, 32'h10);
    chk("R10 discarded", int'(int_req), 0);
    rd(2'd2, d); chk("R10 mask readback", int'(d), 16);
    addr = 2'd0;
    pulse(8'h10, 4);
    step(3);
    wr(2'd2, 32'h0);
    step(3);
    chk("R10 nothing latched", int'(int_req), 0);

    // R6 mode off
    wr(2'd1, 32'h100);
    pulse(8'h08, 3);
    chk("R6 pending", int'(int_req), 1);
    wr(2'd1, 32'h000);
    chk("R6 off silent", int'(int_req), 0);
    pulse(8'h01, 3);
    step(2);
    wr(2'd1, 32'h100);
    step(3);
    chk("R6 dropped", int'(int_req), 0);

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule